// File: doc/BRIEF.md
# Message Register Interrupt Unit

This unit holds a small bank of 32-bit message registers. Software or another bus agent writes a data word into one of them to pass it to the processor. When the write lands on a register whose interrupt is enabled and not masked, that register's pending status is set and its request line to the interrupt controller rises.

A pending request is cleared in one of two ways. The processor can read the message register, which both fetches the word and retires the interrupt. It can also write a one to that register's status bit in the control register; status bits written as zero are left alone. The same control register holds the per-register enable bits. Priority arbitration and vector delivery belong to the interrupt controller downstream. The mask input comes from that controller.

The register bus has one address, separate write and read strobes, and a read data register that presents the result one cycle after the read strobe.

Top module: `msg_irq_unit`

## Requirements
- R1: After reset every message word, enable bit and status bit is zero, `msg_irq` is all zeros and `bus_rdata` is zero.
- R2: A write to address i (0 to 3) stores `bus_wdata` in message register i. A read strobe loads the addressed value into `bus_rdata` on the next clock edge. In a cycle that follows no read strobe, `bus_rdata` is zero.
- R3: A write to message register i sets its status bit when enable bit i is 1 and `irq_mask[i]` is 0. If enable bit i is 0, the status bit keeps its value.
- R4: A write to message register i while `irq_mask[i]` is 1 does not set its status. Clearing the mask afterwards raises no request.
- R5: A read of message register i with no write in the same cycle clears status bit i.
- R6: The control register sits at address 4. A write to it loads the enable bits from `bus_wdata[3:0]`. Each 1 in `bus_wdata[19:16]` clears the matching status bit. Each 0 there leaves that status bit unchanged.
- R7: A write and a read of the same message register in one cycle leave its status set if the write sets it. The read returns the old word, and the register then holds the new word.
- R8: `msg_irq[i]` is status i AND enable i AND NOT `irq_mask[i]`. It follows the mask input in the same cycle.
- R9: A read of the control register returns the enable bits in 3:0 and the status bits in 19:16, with all other bits zero. Addresses 5 to 7 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address: 0 to 3 message registers, 4 control register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_mask | input | 4 | Per-register mask from the interrupt controller |
| msg_irq | output | 4 | Per-register interrupt request |

## Verification
A status bit that is wrongly set or left standing shows on `msg_irq` in the first cycle after the offending edge, as long as the register is enabled and unmasked. It also shows in the next read of the control register. A bad data capture appears only at the next read of that register, one cycle after the read strobe. The bench therefore compares `msg_irq` after every bus cycle and reads back often. Random sequences mix writes, reads, clear-by-one writes and mask changes. Directed cases cover the masked write, the combined write and read, and the unmapped addresses.

// File: rtl/msg_irq_pkg.sv
// Shared types for the message register interrupt unit.
package msg_irq_pkg;
    // Kind of register a bus address selects.
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_MSG  = 2'd1,
        ACC_CTRL = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/msg_addr_dec.sv
// Address decoder: turns one bus access into per-register write/read hits.
// Assumes the control register sits directly above the message registers.
module msg_addr_dec
    import msg_irq_pkg::*;
#(
    parameter int NUM_MSG = 4,
    parameter int ADDR_W  = 3
) (
    input  logic               wr,
    input  logic               rd,
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_MSG-1:0] msg_wr,
    output logic [NUM_MSG-1:0] msg_rd,
    output logic               ctrl_wr,
    output acc_kind_e          kind
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_MSG);

    for (genvar i = 0; i < NUM_MSG; i++) begin : g_hit
        assign msg_wr[i] = wr && (addr == ADDR_W'(i));
        assign msg_rd[i] = rd && (addr == ADDR_W'(i));
    end

    assign ctrl_wr = wr && (addr == CTRL_ADDR);

    // Classify the address for the read path.
    always_comb begin
        if (32'(addr) < NUM_MSG)    kind = ACC_MSG;
        else if (addr == CTRL_ADDR) kind = ACC_CTRL;
        else                        kind = ACC_NONE;
    end
endmodule

// File: rtl/msg_slot.sv
// One message register with its pending status bit.
// A setting write wins over a clearing read in the same cycle.
module msg_slot #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              rd_hit,
    input  logic              w1c,
    input  logic              arm,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] data_q,
    output logic              pend_q
);
    // Capture the written word.
    always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= '0;
        else if (wr_hit) data_q <= wdata;
    end

    // Set on an armed write, clear on a read or a clear-by-one.
    always_ff @(posedge clk) begin
        if (!rst_n)                pend_q <= 1'b0;
        else if (wr_hit && arm)    pend_q <= 1'b1;
        else if (rd_hit || w1c)    pend_q <= 1'b0;
    end
endmodule

// File: rtl/msg_ctrl_reg.sv
// Control register: holds the enable bits and decodes the clear-by-one status field.
// Assumes NUM_MSG fits below STAT_LSB and that the status field fits in DATA_W.
module msg_ctrl_reg #(
    parameter int NUM_MSG  = 4,
    parameter int DATA_W   = 32,
    parameter int STAT_LSB = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_wr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_MSG-1:0] enable_q,
    output logic [NUM_MSG-1:0] w1c
);
    // Load the enable field on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)       enable_q <= '0;
        else if (ctrl_wr) enable_q <= wdata[NUM_MSG-1:0];
    end

    // Clear strobes from the ones in the status field.
    assign w1c = ctrl_wr ? wdata[STAT_LSB +: NUM_MSG] : '0;
endmodule

// File: rtl/msg_rd_mux.sv
// Registered read path: selects a message word or the control layout.
// A cycle without a read strobe returns zero.
module msg_rd_mux
    import msg_irq_pkg::*;
#(
    parameter int NUM_MSG  = 4,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 3,
    parameter int STAT_LSB = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd,
    input  acc_kind_e                      kind,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [NUM_MSG-1:0][DATA_W-1:0] msg_data,
    input  logic [NUM_MSG-1:0]             enable,
    input  logic [NUM_MSG-1:0]             status,
    output logic [DATA_W-1:0]              rdata_q
);
    logic [DATA_W-1:0] sel_word;
    logic [DATA_W-1:0] ctrl_word;

    // Build the control register layout.
    always_comb begin
        ctrl_word = '0;
        ctrl_word[NUM_MSG-1:0]          = enable;
        ctrl_word[STAT_LSB +: NUM_MSG]  = status;
    end

    // Pick the word for the addressed register.
    always_comb begin
        sel_word = '0;
        case (kind)
            ACC_MSG: begin
                for (int i = 0; i < NUM_MSG; i++)
                    if (addr == ADDR_W'(i)) sel_word = msg_data[i];
            end
            ACC_CTRL: sel_word = ctrl_word;
            default:  sel_word = '0;
        endcase
    end

    // Present the read result one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata_q <= '0;
        else if (rd) rdata_q <= sel_word;
        else         rdata_q <= '0;
    end
endmodule

// File: rtl/msg_irq_unit.sv
// Message register interrupt unit top: message bank, control register,
// read path and request outputs. Mask comes from the interrupt controller.
module msg_irq_unit
    import msg_irq_pkg::*;
#(
    parameter int NUM_MSG  = 4,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 3,
    parameter int STAT_LSB = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_MSG-1:0] irq_mask,
    output logic [NUM_MSG-1:0] msg_irq
);
    logic [NUM_MSG-1:0]             msg_wr;
    logic [NUM_MSG-1:0]             msg_rd;
    logic                           ctrl_wr;
    acc_kind_e                      kind;
    logic [NUM_MSG-1:0]             enable_q;
    logic [NUM_MSG-1:0]             w1c;
    logic [NUM_MSG-1:0]             status_q;
    logic [NUM_MSG-1:0]             arm;
    logic [NUM_MSG-1:0][DATA_W-1:0] msg_data;

    msg_addr_dec #(.NUM_MSG(NUM_MSG), .ADDR_W(ADDR_W)) u_dec (
        .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
        .msg_wr(msg_wr), .msg_rd(msg_rd), .ctrl_wr(ctrl_wr), .kind(kind)
    );

    msg_ctrl_reg #(.NUM_MSG(NUM_MSG), .DATA_W(DATA_W), .STAT_LSB(STAT_LSB)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wdata(bus_wdata),
        .enable_q(enable_q), .w1c(w1c)
    );

    // A write may set status only when enabled and unmasked.
    assign arm = enable_q & ~irq_mask;

    for (genvar i = 0; i < NUM_MSG; i++) begin : g_slot
        msg_slot #(.DATA_W(DATA_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .wr_hit(msg_wr[i]), .rd_hit(msg_rd[i]), .w1c(w1c[i]), .arm(arm[i]),
            .wdata(bus_wdata), .data_q(msg_data[i]), .pend_q(status_q[i])
        );
    end

    msg_rd_mux #(.NUM_MSG(NUM_MSG), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_LSB(STAT_LSB)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd(bus_rd), .kind(kind), .addr(bus_addr),
        .msg_data(msg_data), .enable(enable_q), .status(status_q), .rdata_q(bus_rdata)
    );

    // Request lines toward the interrupt controller.
    assign msg_irq = status_q & enable_q & ~irq_mask;
endmodule

// File: rtl/msg_irq_unit_chk.sv
// Checker for msg_irq_unit: relates bus accesses to the status, data and request state.
module msg_irq_unit_chk #(
    parameter int NUM_MSG  = 4,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 3,
    parameter int STAT_LSB = 16
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           bus_wr,
    input logic                           bus_rd,
    input logic [ADDR_W-1:0]              bus_addr,
    input logic [DATA_W-1:0]              bus_wdata,
    input logic [NUM_MSG-1:0]             irq_mask,
    input logic [NUM_MSG-1:0]             msg_irq,
    input logic [NUM_MSG-1:0]             enable_q,
    input logic [NUM_MSG-1:0]             status_q,
    input logic [NUM_MSG-1:0][DATA_W-1:0] msg_data
);
    for (genvar i = 0; i < NUM_MSG; i++) begin : g_chk
        AST_DATA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(i)) |=> (msg_data[i] == $past(bus_wdata))); // R2
        AST_ARMED_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(i) && enable_q[i] && !irq_mask[i]) |=> status_q[i]); // R3
        AST_MASKED_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(i) && irq_mask[i] && !status_q[i]) |=> !status_q[i]); // R4
        AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && !bus_wr && bus_addr == ADDR_W'(i)) |=> !status_q[i]); // R5
        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(NUM_MSG) && bus_wdata[STAT_LSB + i]) |=> !status_q[i]); // R6
        AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(NUM_MSG)) |=> (enable_q[i] == $past(bus_wdata[i]))); // R6
        AST_REQ_RESPECTS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
            msg_irq[i] |-> (!irq_mask[i] && enable_q[i] && status_q[i])); // R8
    end
endmodule

bind msg_irq_unit msg_irq_unit_chk #(
    .NUM_MSG(NUM_MSG), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_LSB(STAT_LSB)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_mask(irq_mask),
    .msg_irq(msg_irq), .enable_q(enable_q), .status_q(status_q), .msg_data(msg_data)
);

// File: tb/msg_irq_unit_tb.sv
module msg_irq_unit_tb;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] irq_mask = '0;
    logic [N-1:0] msg_irq;

    int checks = 0;
    int errors = 0;

    // Reference state built from the requirements.
    logic [31:0]  m_data [N];
    logic [N-1:0] m_en;
    logic [N-1:0] m_stat;

    always #10 clk = ~clk;

    msg_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_mask(irq_mask), .msg_irq(msg_irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [2:0] a);
        if (a < 3'(N)) return m_data[a];
        if (a == 3'(N)) return {12'b0, m_stat, 12'b0, m_en};
        return 32'h0;
    endfunction

    function automatic logic [N-1:0] model_irq();
        return m_stat & m_en & ~irq_mask;
    endfunction

    // One bus cycle, starting and ending at a falling edge; updates the model and checks.
    task automatic bus(input bit wr, input bit rd, input logic [2:0] a, input logic [31:0] d, input string req);
        logic [31:0] exp_rd;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        exp_rd = rd ? model_read(a) : 32'h0;
        @(posedge clk);
        if (a < 3'(N)) begin
            logic set;
            set = wr && m_en[a] && !irq_mask[a];
            if (wr) m_data[a] = d;
            if (set)     m_stat[a] = 1'b1;
            else if (rd) m_stat[a] = 1'b0;
        end else if (a == 3'(N) && wr) begin
            m_en   = d[N-1:0];
            m_stat = m_stat & ~d[16 +: N];
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check(bus_rdata == exp_rd, req, bus_rdata, exp_rd);
        check(msg_irq == model_irq(), req, 32'(msg_irq), 32'(model_irq()));
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < N; i++) m_data[i] = '0;
        m_en = '0; m_stat = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(bus_rdata == 0, "R1", bus_rdata, 0);
        check(msg_irq == 0, "R1", 32'(msg_irq), 0);
        bus(0, 1, 3'd4, 0, "R1");
        bus(0, 1, 3'd2, 0, "R1");

        // R3 armed write raises request; R2 readback; R5 read clears
        bus(1, 0, 3'd4, 32'h0000_000F, "R6");
        bus(1, 0, 3'd0, 32'hA5A5_1234, "R3");
        check(msg_irq[0] == 1'b1, "R3", 32'(msg_irq), 1);
        bus(0, 1, 3'd0, 0, "R2");
        check(msg_irq[0] == 1'b0, "R5", 32'(msg_irq), 0);
        bus(0, 0, 3'd0, 0, "R2");

        // R4 masked write stays quiet after unmask
        irq_mask = 4'b0010;
        bus(1, 0, 3'd1, 32'h1111_2222, "R4");
        irq_mask = 4'b0000;
        #1;
        check(msg_irq[1] == 1'b0, "R4", 32'(msg_irq), 0);
        bus(0, 1, 3'd4, 0, "R4");

        // R6 zero in status field has no effect, one clears
        bus(1, 0, 3'd2, 32'hDEAD_BEEF, "R6");
        bus(1, 0, 3'd4, 32'h000B_000F, "R6");
        check(msg_irq[2] == 1'b1, "R6", 32'(msg_irq), 1);
        bus(1, 0, 3'd4, 32'h0004_000F, "R6");
        check(msg_irq[2] == 1'b0, "R6", 32'(msg_irq), 0);

        // R7 write and read in the same cycle
        bus(1, 0, 3'd3, 32'h0000_0033, "R7");
        bus(1, 1, 3'd3, 32'h4444_5555, "R7");
        check(msg_irq[3] == 1'b1, "R7", 32'(msg_irq), 1);
        bus(0, 1, 3'd3, 0, "R7");

        // R8 request follows the mask combinationally
        bus(1, 0, 3'd1, 32'h7777_0000, "R8");
        irq_mask = 4'b0010; #1;
        check(msg_irq[1] == 1'b0, "R8", 32'(msg_irq), 0);
        irq_mask = 4'b0000; #1;
        check(msg_irq[1] == 1'b1, "R8", 32'(msg_irq), 1);

        // R3 disabled register keeps status clear; R9 unmapped
        bus(1, 0, 3'd4, 32'h000F_0007, "R6");
        bus(1, 0, 3'd3, 32'h0BAD_0BAD, "R3");
        check(msg_irq[3] == 1'b0, "R3", 32'(msg_irq), 0);
        bus(1, 0, 3'd6, 32'hFFFF_FFFF, "R9");
        bus(0, 1, 3'd6, 0, "R9");
        bus(0, 1, 3'd4, 0, "R9");

        // Random mix of accesses and mask changes
        for (int k = 0; k < 600; k++) begin
            bit w, r;
            logic [2:0] a;
            logic [31:0] d;
            if (($urandom % 8) == 0) irq_mask = 4'($urandom);
            w = ($urandom % 2) == 1;
            r = ($urandom % 3) == 0;
            a = ($urandom % 4 == 0) ? 3'd4 : 3'($urandom % 8);
            d = $urandom;
            if (a == 3'd4 && ($urandom % 2) == 1) d[3:0] = 4'hF;
            bus(w, r, a, d, "R8");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule